// File: doc/BRIEF.md
# SAR ADC Control Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software selects one of four analog inputs through a small byte-wide register port and requests a conversion. The block then drives the input-mux select and a 10-bit trial code to an external resistor-string DAC. After each DAC update it waits a fixed number of clocks for settling. It then samples a one-bit comparator that reports whether the selected input is at or above the DAC output. Ten such steps resolve the code from the most significant bit down.

When the last bit is decided, the code is stored in a pair of byte-wide result registers. An end-of-conversion flag is raised and the sequencer returns to idle. The analog comparator, DAC and multiplexer sit outside the block. A later conversion replaces the stored result whether or not software has read it.

Top module: `sarAdcSeq`

## Requirements
- R1: After reset `busy` is 0, `dacCode` and `muxSel` are 0, and every register address reads 0x00.
- R2: Register map on `regAddr`:
  - Address 0 is control, with channel at bits 5:4 (read/write), end-of-conversion flag at bit 3 (read-only) and start at bit 0. Its other bits read 0.
  - Address 1 reads result bits 9:2.
  - Address 2 reads result bits 1:0 in bits 7:6, with bits 5:0 reading 0.
  - Address 3 reads 0.
- R3: Writing address 0 with bit 0 set while idle sets the start bit (readable in the next cycle). `busy` rises one clock later, and the start bit then reads 0.
- R4: In the first busy cycle `dacCode` equals the midpoint code 0x200, with only the MSB set.
- R5: Every SETTLE clocks (default 4) the current trial bit is kept if `compIn` is 1 and cleared if 0, and the next lower bit is set. `dacCode` holds steady in between.
- R6: A conversion lasts exactly 10*SETTLE busy cycles. `busy` then falls, the end-of-conversion flag reads 1, and the result registers hold the final code. With an ideal comparator (input ≥ code gives 1), the final code equals the input level.
- R7: `muxSel` takes the channel field at the moment the conversion starts and holds it until the end. A channel write during a conversion changes only the stored field.
- R8: A start written while busy, or while a start is already pending, is ignored. The running conversion is not restarted, no second conversion follows, and the end-of-conversion flag is not cleared.
- R9: An accepted start clears the end-of-conversion flag. A control write with bit 0 clear leaves the flag unchanged.
- R10: Each finished conversion overwrites the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| compIn | input | 1 | Comparator: 1 when input ≥ DAC output |
| muxSel | output | 2 | Analog input multiplexer select |
| dacCode | output | 10 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest case to reach is a control write that lands in the middle of a running conversion. Such a write may carry a new channel, a start request, or both, and it must not disturb the mux select, the trial sequence or the flag. The bench exercises this by injecting control writes at chosen step boundaries inside a traced conversion, and at random steps in the random phase. It follows `dacCode` step by step against a bench-side model of the bit decisions. Directed levels 0, 1, 511, 512 and 1023 push the comparator to all-ones and all-zeros decision chains.

// File: rtl/sarPkg.sv
package sarPkg;
  localparam int RES_BITS  = 10;
  localparam int IDX_W     = $clog2(RES_BITS);
  localparam int CHAN_BITS = 2;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2;

  // control register bit positions (software-visible layout)
  localparam int CH_LO     = 4;
  localparam int EOC_BIT   = 3;
  localparam int START_BIT = 0;

  // register addresses
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LOW  = 2'd2;

  typedef struct packed {
    logic             load;    // begin conversion: load midpoint, latch channel
    logic             step;    // settle elapsed: resolve current bit
    logic             finish;  // last bit resolved: store result
    logic [IDX_W-1:0] bitIdx;  // bit currently under trial
  } sarStrobeT;
endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarPkg::*;
#(
  parameter int RES_W  = RES_BITS,
  parameter int SETTLE = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output sarStrobeT strb,
  output logic      busy
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  typedef enum logic {ST_IDLE, ST_CONV} stateT;

  stateT            state;
  logic [CNT_W-1:0] settleCnt;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      idx       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state     <= ST_CONV;
            settleCnt <= '0;
            idx       <= IDX_W'(RES_W - 1);
          end
        end
        default: begin
          if (settleCnt == CNT_LAST) begin
            settleCnt <= '0;
            if (idx == '0) state <= ST_IDLE;
            else           idx   <= idx - IDX_W'(1);
          end else begin
            settleCnt <= settleCnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == ST_IDLE) && startReq;
    strb.step   = (state == ST_CONV) && (settleCnt == CNT_LAST);
    strb.finish = strb.step && (idx == '0);
    strb.bitIdx = idx;
    busy        = (state == ST_CONV);
  end
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int RES_W = RES_BITS,
  parameter int CH_W  = CHAN_BITS,
  parameter int REG_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobeT         strb,
  input  logic              busy,
  input  logic              compIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              startReq,
  output logic [RES_W-1:0]  dacCode,
  output logic [CH_W-1:0]   muxSel
);
  localparam int LOW_W = RES_W - REG_W;
  localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

  logic [CH_W-1:0]  chanReg;
  logic [CH_W-1:0]  convChan;
  logic             eocFlag;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] result;
  logic [RES_W-1:0] nextTrial;
  logic             ctrlWr;
  logic             startAcc;

  assign ctrlWr   = regWrEn && (regAddr == ADR_CTRL);
  assign startAcc = ctrlWr && regWrData[START_BIT] && !busy && !startReq;

  always_comb begin
    nextTrial = trial;
    nextTrial[strb.bitIdx] = compIn;
    if (strb.bitIdx != '0) nextTrial[strb.bitIdx - IDX_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg  <= '0;
      convChan <= '0;
      eocFlag  <= 1'b0;
      startReq <= 1'b0;
      trial    <= '0;
      result   <= '0;
    end else begin
      if (ctrlWr) chanReg <= regWrData[CH_LO +: CH_W];
      if (strb.load) begin
        startReq <= 1'b0;
        trial    <= MID_CODE;
        convChan <= chanReg;
      end else if (startAcc) begin
        startReq <= 1'b1;
        eocFlag  <= 1'b0;
      end
      if (strb.step) trial <= nextTrial;
      if (strb.finish) begin
        result  <= nextTrial;
        eocFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_CTRL: begin
        regRdData[CH_LO +: CH_W] = chanReg;
        regRdData[EOC_BIT]       = eocFlag;
        regRdData[START_BIT]     = startReq;
      end
      ADR_HIGH: regRdData = result[RES_W-1 -: REG_W];
      ADR_LOW:  regRdData = {result[LOW_W-1:0], {(REG_W-LOW_W){1'b0}}};
      default:  regRdData = '0;
    endcase
  end

  assign dacCode = trial;
  assign muxSel  = convChan;
endmodule

// File: rtl/sarAdcSeq.sv
module sarAdcSeq
  import sarPkg::*;
#(
  parameter int RES_W  = RES_BITS,
  parameter int CH_W   = CHAN_BITS,
  parameter int REG_W  = BYTE_W,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              compIn,
  output logic [CH_W-1:0]   muxSel,
  output logic [RES_W-1:0]  dacCode,
  output logic              busy
);
  sarStrobeT strb;
  logic      startReq;

  sarCtrl #(.RES_W(RES_W), .SETTLE(SETTLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .strb(strb), .busy(busy)
  );

  sarDatapath #(.RES_W(RES_W), .CH_W(CH_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .compIn(compIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .startReq(startReq), .dacCode(dacCode),
    .muxSel(muxSel)
  );
endmodule

// File: rtl/sarAdcSeq_chk.sv
module sarAdcSeq_chk #(
  parameter int RES_W  = 10,
  parameter int CH_W   = 2,
  parameter int SETTLE = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic [RES_W-1:0] dacCode,
  input logic [CH_W-1:0]  muxSel
);
  localparam logic [RES_W-1:0] MID = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] prevDac;
  logic             prevBusy;
  int               gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDac  <= '0;
      prevBusy <= 1'b0;
      gap      <= 0;
    end else begin
      prevDac  <= dacCode;
      prevBusy <= busy;
      if (!busy)                   gap <= 0;
      else if (dacCode != prevDac) gap <= 1;
      else                         gap <= gap + 1;
    end
  end

  AST_MID_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> dacCode == MID); // R4
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && prevBusy) |-> $stable(muxSel)); // R7
  AST_DAC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> dacCode != '0); // R5
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && prevBusy && dacCode != prevDac) |-> gap == SETTLE); // R5
  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && prevBusy) |-> gap == SETTLE); // R6
endmodule

bind sarAdcSeq sarAdcSeq_chk #(.RES_W(RES_W), .CH_W(CH_W), .SETTLE(SETTLE)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .dacCode(dacCode), .muxSel(muxSel)
);

// File: tb/sarAdcSeq_tb_top.sv
module sarAdcSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SET = 4;
  localparam int RES = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       compIn;
  logic [1:0] muxSel;
  logic [9:0] dacCode;
  logic       busy;

  int  ana [4];
  int  vecs = 0;
  int  miss = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb compIn = (ana[muxSel] >= int'(dacCode));

  sarAdcSeq #(.SETTLE(SET)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .compIn(compIn),
    .muxSel(muxSel), .dacCode(dacCode), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int trialAfter(input int lvl, input int steps);
    int t = 0;
    for (int b = RES - 1; b >= RES - steps; b--) begin
      t |= (1 << b);
      if (lvl < t) t &= ~(1 << b);
    end
    if (steps < RES) t |= (1 << (RES - 1 - steps));
    return t;
  endfunction

  task automatic tick();
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = 2'(a);
    #1;
    v = int'(regRdData);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regAddr = 2'(a); regWrData = 8'(d); regWrEn = 1'b1;
    tick();
  endtask

  // full traced conversion; optional control write injected after step midStep
  task automatic convert(input int ch, input int midStep, input int midData);
    int v, lvl, finalCh;
    lvl = ana[ch];
    finalCh = ch;
    wr(0, (ch << 4) | 1);
    rd(0, v);
    chk(v == ((ch << 4) | 1), "R3/R9 start pending, eoc cleared", v, (ch << 4) | 1);
    chk(busy == 1'b0, "R3 busy one clock after write", int'(busy), 0);
    tick();
    chk(busy == 1'b1, "R3 busy rises", int'(busy), 1);
    chk(int'(dacCode) == 'h200, "R4 midpoint", int'(dacCode), 'h200);
    chk(int'(muxSel) == ch, "R7 mux latched", int'(muxSel), ch);
    rd(0, v);
    chk((v & 1) == 0, "R3 start self-clears", v & 1, 0);
    for (int j = 1; j <= RES; j++) begin
      for (int k = 0; k < SET - 1; k++) begin
        if (j - 1 == midStep && k == 0) begin
          regAddr = 2'd0; regWrData = 8'(midData); regWrEn = 1'b1;
          finalCh = (midData >> 4) & 3;
        end
        tick();
        chk(int'(dacCode) == trialAfter(lvl, j - 1), "R5 code held during settle",
            int'(dacCode), trialAfter(lvl, j - 1));
        chk(int'(muxSel) == ch, "R7 mux held", int'(muxSel), ch);
      end
      tick();
      if (j < RES) begin
        chk(busy == 1'b1, "R6 still busy", int'(busy), 1);
        chk(int'(dacCode) == trialAfter(lvl, j), "R5 step code", int'(dacCode),
            trialAfter(lvl, j));
      end else begin
        chk(busy == 1'b0, "R6 done after 10*SETTLE", int'(busy), 0);
      end
    end
    rd(1, v);
    chk(v == (lvl >> 2), "R6/R10 high byte", v, lvl >> 2);
    rd(2, v);
    chk(v == ((lvl & 3) << 6), "R2 low byte layout", v, (lvl & 3) << 6);
    rd(0, v);
    chk(v == ((finalCh << 4) | 8), "R2/R6/R7 ctrl after done", v, (finalCh << 4) | 8);
    repeat (3) tick();
    chk(busy == 1'b0, "R8 no second conversion", int'(busy), 0);
  endtask

  initial begin
    int v;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4; i++) ana[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(busy == 0 && dacCode == 0 && muxSel == 0, "R1 reset outputs",
        int'({busy, dacCode, muxSel}), 0);
    rstN = 1'b1;
    tick();

    // directed corner levels, R6
    ana[0] = 0; ana[1] = 1023; ana[2] = 511; ana[3] = 512;
    for (int c = 0; c < 4; c++) convert(c, -1, 0);
    ana[1] = 1;
    convert(1, -1, 0);

    // R7 channel change mid-conversion
    ana[2] = 'h2A5; ana[3] = 77;
    convert(2, 3, 3 << 4);
    // R9 plain control write keeps eoc
    wr(0, 1 << 4);
    rd(0, v);
    chk(v == ((1 << 4) | 8), "R9 eoc kept on plain write", v, (1 << 4) | 8);
    // R8 start while busy ignored
    convert(0, 5, (2 << 4) | 1);
    // R2 unused address
    rd(3, v);
    chk(v == 0, "R2 address 3 reads zero", v, 0);
    // R10 overwrite without intermediate reads
    ana[1] = 100;
    convert(1, -1, 0);
    ana[1] = 900;
    convert(1, -1, 0);

    // random phase
    for (int n = 0; n < 40; n++) begin
      int ch, ms, md;
      for (int i = 0; i < 4; i++) ana[i] = int'($urandom_range(0, 1023));
      ch = int'($urandom_range(0, 3));
      ms = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, RES - 1)) : -1;
      md = int'($urandom_range(0, 3) << 4) | int'($urandom_range(0, 1));
      convert(ch, ms, md);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++; miss++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule